// File: doc/BRIEF.md
# Stereo Sample FIFO with Watermarks

This block buffers 24-bit stereo audio samples for one direction of a serial digital audio link. Both sides move words one at a time: a left strobe and a right strobe on the write side, and a left strobe and a right strobe on the read side. In the transmit direction the host writes and the line encoder reads. In the receive direction the line decoder writes and the host reads. Storage holds `DEPTH` left/right pairs. A pair counts as stored only once its right word has been accepted after its left word.

The parameter `IS_TX` selects the watermark sense. A transmit instance raises its flag when the FIFO is nearly empty. A receive instance raises its flag when the FIFO is filled to a chosen level. The flag drives a DMA request through an enable bit. It has no clear input: it falls only when the FIFO is serviced.

Control inputs add four behaviours:
- forced zero on every read;
- write rejection (FIFO off);
- a collapse of the FIFO to its single oldest pair;
- auto-sync, which keeps each strobe on its own channel's slot.

Underrun, overrun and resync events appear as one-cycle pulses. A transmit mode field decodes onto these inputs: 0 gives `zero_rd_i`, 1 gives normal operation, and 2 gives `reset_one_i`.

Top module: `stereo_sample_fifo`

## Requirements
- R1: After reset the FIFO holds no pairs. `rd_data_o`, `xrun_o`, `resync_o` and `dma_req_o` are 0. With `wm_sel_i`=0 the transmit flag is 1 and the receive flag is 0.
- R2: Pairs leave in the order they were committed. A left read followed by a right read returns the stored left word and then the right word, with the data on `rd_data_o` one cycle after the strobe. The pair is freed on the right read.
- R3: A commit while `DEPTH` pairs are held and no pair is freed in the same cycle drops the new pair. The level stays at `DEPTH` and `xrun_o` pulses for one cycle.
- R4: A read strobe while the FIFO is empty returns 0 and pulses `xrun_o`.
- R5: Transmit flag (`IS_TX`=1) is 1 when the stored pair count is at most 0, 4, 8 or 12, for `wm_sel_i` codes 0, 1, 2 or 3.
- R6: Receive flag (`IS_TX`=0) is 1 when the stored pair count is at least 1, 4, 8 or 16, for `wm_sel_i` codes 0, 1, 2 or 3.
- R7: The flag has no clear path and changes only with the level or `wm_sel_i`. `dma_req_o` equals the flag while `dma_en_i`=1 and is 0 while `dma_en_i`=0.
- R8: While `zero_rd_i`=1 every read returns 0 but still consumes its word.
- R9: While `wr_off_i`=1 write strobes are ignored and no pair is committed.
- R10: A cycle with `reset_one_i`=1 leaves exactly one pair stored, the oldest one, and discards any half-written or half-read pair. Strobes in that cycle are ignored.
- R11: With `autosync_i`=1 on the write side:
  - a second left write without a right write replaces the held left word;
  - a right write with no left word held is dropped;
  - each of these pulses `resync_o`.
- R12: With `autosync_i`=1 on the read side:
  - a left read after a left read discards the current pair and returns the next pair's left word;
  - a right read before a left read returns the current pair's right word and frees the pair;
  - each of these pulses `resync_o`.
- R13: With `autosync_i`=0 the strobes only step through the slots in strict left/right alternation. A right strobe then lands in a left slot and the reverse, and `resync_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_l_i | input | 1 | Write strobe, left channel (wins over `wr_r_i`) |
| wr_r_i | input | 1 | Write strobe, right channel |
| wr_data_i | input | W | Write sample |
| rd_l_i | input | 1 | Read strobe, left channel (wins over `rd_r_i`) |
| rd_r_i | input | 1 | Read strobe, right channel |
| rd_data_o | output | W | Read sample, registered |
| wm_sel_i | input | 2 | Watermark code |
| autosync_i | input | 1 | Channel auto-sync enable |
| zero_rd_i | input | 1 | Reads return zero |
| wr_off_i | input | 1 | Reject writes |
| reset_one_i | input | 1 | Collapse to the oldest pair |
| dma_en_i | input | 1 | DMA request enable |
| wm_o | output | 1 | Watermark flag |
| dma_req_o | output | 1 | DMA request |
| resync_o | output | 1 | Resync pulse |
| xrun_o | output | 1 | Underrun/overrun pulse |

## Verification
A wrong level count shows directly on `wm_o`. A sweep over every fill level and every watermark code exposes an off-by-one error at once, in the cycle after the offending commit or free. A wrong pointer or wrong slot choice shows as a misplaced sample on `rd_data_o` one cycle after the read strobe. Lost or doubled pairs show as an early or missing underrun pulse at the end of a drain. Errors in the alignment state show as a wrong word or a missing `resync_o` pulse on the very next strobe.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // transmit: flag when level <= mark
  function automatic int unsigned tx_mark(logic [1:0] sel);
    return 4 * int'(sel);
  endfunction
  // receive: flag when level >= mark
  function automatic int unsigned rx_mark(logic [1:0] sel);
    return (sel == 2'd0) ? 1 : (2 << sel);
  endfunction
endpackage

// File: rtl/sfifo_wr_pair.sv
module sfifo_wr_pair #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_l_i,
  input  logic         wr_r_i,
  input  logic [W-1:0] data_i,
  input  logic         off_i,
  input  logic         autosync_i,
  input  logic         clear_i,
  output logic         commit_o,
  output logic [W-1:0] left_o,
  output logic         resync_o
);
  logic         hold_v_q, hold_v_d;
  logic [W-1:0] hold_q;
  logic         load;
  logic         l_go, r_go;

  assign l_go   = wr_l_i && !off_i && !clear_i;
  assign r_go   = wr_r_i && !wr_l_i && !off_i && !clear_i;
  assign left_o = hold_q;

  always_comb begin
    commit_o = 1'b0;
    resync_o = 1'b0;
    load     = 1'b0;
    hold_v_d = hold_v_q;
    if (l_go) begin
      if (!hold_v_q) begin
        load = 1'b1; hold_v_d = 1'b1;
      end else if (!autosync_i) begin
        commit_o = 1'b1; hold_v_d = 1'b0;
      end else begin
        load = 1'b1; resync_o = 1'b1;   // restart the pair
      end
    end else if (r_go) begin
      if (hold_v_q) begin
        commit_o = 1'b1; hold_v_d = 1'b0;
      end else if (!autosync_i) begin
        load = 1'b1; hold_v_d = 1'b1;   // right word lands in left slot
      end else begin
        resync_o = 1'b1;                // orphan right word dropped
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q <= 1'b0;
      hold_q   <= '0;
    end else begin
      hold_v_q <= clear_i ? 1'b0 : hold_v_d;
      if (load) hold_q <= data_i;
    end
  end
endmodule

// File: rtl/sfifo_rd_align.sv
module sfifo_rd_align (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_l_i,
  input  logic rd_r_i,
  input  logic autosync_i,
  input  logic clear_i,
  input  logic empty_i,
  input  logic last_i,
  output logic pop_o,
  output logic skip_o,
  output logic slot_r_o,
  output logic valid_o,
  output logic underrun_o,
  output logic resync_o
);
  logic ph_q, ph_d;  // 1: right slot of head pair is next

  always_comb begin
    pop_o = 1'b0; skip_o = 1'b0; slot_r_o = 1'b0;
    valid_o = 1'b0; underrun_o = 1'b0; resync_o = 1'b0;
    ph_d = ph_q;
    if (!clear_i && (rd_l_i || rd_r_i)) begin
      if (empty_i) begin
        underrun_o = 1'b1;
      end else if (rd_l_i) begin
        if (!ph_q) begin
          valid_o = 1'b1; ph_d = 1'b1;
        end else if (!autosync_i) begin
          valid_o = 1'b1; slot_r_o = 1'b1; pop_o = 1'b1; ph_d = 1'b0;
        end else begin
          resync_o = 1'b1; pop_o = 1'b1;
          if (last_i) begin
            underrun_o = 1'b1; ph_d = 1'b0;
          end else begin
            valid_o = 1'b1; skip_o = 1'b1;
          end
        end
      end else begin
        if (ph_q) begin
          valid_o = 1'b1; slot_r_o = 1'b1; pop_o = 1'b1; ph_d = 1'b0;
        end else if (!autosync_i) begin
          valid_o = 1'b1; ph_d = 1'b1;
        end else begin
          resync_o = 1'b1; valid_o = 1'b1; slot_r_o = 1'b1; pop_o = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ph_q <= 1'b0;
    else if (clear_i) ph_q <= 1'b0;
    else              ph_q <= ph_d;
  end
endmodule

// File: rtl/sfifo_mark.sv
module sfifo_mark #(
  parameter bit IS_TX = 1'b1,
  parameter int CW    = 5
) (
  input  logic [CW-1:0] level_i,
  input  logic [1:0]    sel_i,
  output logic          flag_o
);
  import sfifo_pkg::*;
  generate
    if (IS_TX) begin : g_tx
      assign flag_o = 32'(level_i) <= tx_mark(sel_i);
    end else begin : g_rx
      assign flag_o = 32'(level_i) >= rx_mark(sel_i);
    end
  endgenerate
endmodule

// File: rtl/stereo_sample_fifo.sv
module stereo_sample_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 16,
  parameter bit IS_TX = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_l_i,
  input  logic         wr_r_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_l_i,
  input  logic         rd_r_i,
  output logic [W-1:0] rd_data_o,
  input  logic [1:0]   wm_sel_i,
  input  logic         autosync_i,
  input  logic         zero_rd_i,
  input  logic         wr_off_i,
  input  logic         reset_one_i,
  input  logic         dma_en_i,
  output logic         wm_o,
  output logic         dma_req_o,
  output logic         resync_o,
  output logic         xrun_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem_l [DEPTH];
  logic [W-1:0]  mem_r [DEPTH];
  logic [AW-1:0] rp_q, wp_q, rd_idx;
  logic [CW-1:0] count_q;
  logic [W-1:0]  pair_l, word;
  logic commit, wr_resync;
  logic pop, skip, slot_r, rd_ok, underrun, rd_resync;
  logic full, push_ok, overrun;

  sfifo_wr_pair #(.W(W)) u_wr (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_l_i(wr_l_i), .wr_r_i(wr_r_i),
    .data_i(wr_data_i), .off_i(wr_off_i), .autosync_i(autosync_i),
    .clear_i(reset_one_i), .commit_o(commit), .left_o(pair_l),
    .resync_o(wr_resync)
  );

  sfifo_rd_align u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_l_i(rd_l_i), .rd_r_i(rd_r_i),
    .autosync_i(autosync_i), .clear_i(reset_one_i),
    .empty_i(count_q == '0), .last_i(count_q == CW'(1)),
    .pop_o(pop), .skip_o(skip), .slot_r_o(slot_r), .valid_o(rd_ok),
    .underrun_o(underrun), .resync_o(rd_resync)
  );

  sfifo_mark #(.IS_TX(IS_TX), .CW(CW)) u_mark (
    .level_i(count_q), .sel_i(wm_sel_i), .flag_o(wm_o)
  );

  assign dma_req_o = wm_o & dma_en_i;
  assign full      = count_q == CW'(DEPTH);
  assign push_ok   = commit && (!full || pop);
  assign overrun   = commit && full && !pop;
  assign rd_idx    = rp_q + AW'(skip);
  assign word      = slot_r ? mem_r[rd_idx] : mem_l[rd_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rp_q      <= '0;
      wp_q      <= '0;
      count_q   <= '0;
      rd_data_o <= '0;
      xrun_o    <= 1'b0;
      resync_o  <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        mem_l[i] <= '0;
        mem_r[i] <= '0;
      end
    end else begin
      xrun_o   <= overrun | underrun;
      resync_o <= wr_resync | rd_resync;
      if (rd_l_i || rd_r_i) rd_data_o <= (rd_ok && !zero_rd_i) ? word : '0;
      if (reset_one_i) begin
        wp_q    <= rp_q + AW'(1);  // keep only the head pair
        count_q <= CW'(1);
      end else begin
        rp_q    <= rp_q + AW'(pop);
        wp_q    <= wp_q + AW'(push_ok);
        count_q <= count_q + CW'(push_ok) - CW'(pop);
        if (push_ok) begin
          mem_l[wp_q] <= pair_l;
          mem_r[wp_q] <= wr_data_i;
        end
      end
    end
  end
endmodule

// File: rtl/sfifo_checker.sv
module sfifo_checker #(
  parameter int W     = 24,
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reset_one_i,
  input logic          wr_off_i,
  input logic          zero_rd_i,
  input logic          rd_l_i,
  input logic          rd_r_i,
  input logic [W-1:0]  rd_data_o,
  input logic          xrun_o,
  input logic [CW-1:0] count_q
);
  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));

  assert_collapse_one_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_one_i |=> count_q == CW'(1));

  assert_off_no_fill_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_off_i && !reset_one_i |=> count_q <= $past(count_q));

  assert_zero_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_rd_i && (rd_l_i || rd_r_i) |=> rd_data_o == '0);

  assert_xrun_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xrun_o |-> ($past(count_q) <= CW'(1)) || ($past(count_q) == CW'(DEPTH)));

  assert_level_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reset_one_i |=> (count_q <= $past(count_q) + 1) && (count_q + 1 >= $past(count_q)));
endmodule

bind stereo_sample_fifo sfifo_checker #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reset_one_i(reset_one_i),
  .wr_off_i(wr_off_i), .zero_rd_i(zero_rd_i), .rd_l_i(rd_l_i),
  .rd_r_i(rd_r_i), .rd_data_o(rd_data_o), .xrun_o(xrun_o),
  .count_q(count_q)
);

// File: tb/tb_stereo_sample_fifo.sv
module tb_stereo_sample_fifo;
  localparam int W = 24;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic wr_l = 0, wr_r = 0, rd_l = 0, rd_r = 0;
  logic [W-1:0] wr_data = '0;
  logic [1:0] wm_sel = '0;
  logic autosync = 0, zero_rd = 0, wr_off = 0, reset_one = 0, dma_en = 0;
  logic [W-1:0] rd_tx, rd_rx;
  logic wm_tx, dma_tx, resync_tx, xrun_tx;
  logic wm_rx, dma_rx, resync_rx, xrun_rx;

  int checks = 0;
  int errors = 0;

  stereo_sample_fifo #(.W(W), .DEPTH(DEPTH), .IS_TX(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_l_i(wr_l), .wr_r_i(wr_r),
    .wr_data_i(wr_data), .rd_l_i(rd_l), .rd_r_i(rd_r), .rd_data_o(rd_tx),
    .wm_sel_i(wm_sel), .autosync_i(autosync), .zero_rd_i(zero_rd),
    .wr_off_i(wr_off), .reset_one_i(reset_one), .dma_en_i(dma_en),
    .wm_o(wm_tx), .dma_req_o(dma_tx), .resync_o(resync_tx), .xrun_o(xrun_tx)
  );

  stereo_sample_fifo #(.W(W), .DEPTH(DEPTH), .IS_TX(1'b0)) dut_rx (
    .clk_i(clk), .rst_ni(rst_n), .wr_l_i(wr_l), .wr_r_i(wr_r),
    .wr_data_i(wr_data), .rd_l_i(rd_l), .rd_r_i(rd_r), .rd_data_o(rd_rx),
    .wm_sel_i(wm_sel), .autosync_i(autosync), .zero_rd_i(zero_rd),
    .wr_off_i(wr_off), .reset_one_i(reset_one), .dma_en_i(dma_en),
    .wm_o(wm_rx), .dma_req_o(dma_rx), .resync_o(resync_rx), .xrun_o(xrun_rx)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] lw(int k); return 24'h100000 + W'(k); endfunction
  function automatic logic [W-1:0] rw(int k); return 24'h200000 + W'(k); endfunction
  function automatic int txm(int s); return 4 * s; endfunction
  function automatic int rxm(int s); return (s == 0) ? 1 : (2 << s); endfunction

  task automatic wr_word(bit right, logic [W-1:0] d);
    wr_l = !right; wr_r = right; wr_data = d;
    @(negedge clk);
    wr_l = 0; wr_r = 0;
  endtask

  task automatic rd_word(bit right, output logic [W-1:0] d);
    rd_l = !right; rd_r = right;
    @(negedge clk);
    rd_l = 0; rd_r = 0;
    d = rd_tx;
  endtask

  task automatic push_pair(logic [W-1:0] l, logic [W-1:0] r);
    wr_word(1'b0, l);
    wr_word(1'b1, r);
  endtask

  initial begin
    logic [W-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_data", rd_tx, 0);
    chk("R1 xrun", xrun_tx, 0);
    chk("R1 resync", resync_tx, 0);
    chk("R1 dma", dma_tx, 0);
    chk("R1 tx flag", wm_tx, 1);
    chk("R1 rx flag", wm_rx, 0);

    // fill sweep over every level and code: R5 R6 R7 R3
    dma_en = 1;
    for (int n = 0; n <= DEPTH; n++) begin
      for (int s = 0; s < 4; s++) begin
        wm_sel = 2'(s);
        #1;
        chk($sformatf("R5 tx flag n=%0d s=%0d", n, s), wm_tx, (n <= txm(s)));
        chk($sformatf("R6 rx flag n=%0d s=%0d", n, s), wm_rx, (n >= rxm(s)));
        chk($sformatf("R7 dma n=%0d s=%0d", n, s), dma_tx, (n <= txm(s)));
      end
      push_pair(lw(n), rw(n));
      chk($sformatf("R3 xrun after push %0d", n), xrun_tx, (n == DEPTH));
    end
    @(negedge clk);
    chk("R3 xrun is a pulse", xrun_tx, 0);
    wm_sel = 2'd3;
    #1;
    chk("R3 level held at depth tx", wm_tx, 0);
    chk("R3 level held at depth rx", wm_rx, 1);

    // drain in order: R2
    for (int k = 0; k < DEPTH; k++) begin
      rd_word(1'b0, d); chk($sformatf("R2 left %0d", k), d, lw(k));
      rd_word(1'b1, d); chk($sformatf("R2 right %0d", k), d, rw(k));
    end
    rd_word(1'b0, d);
    chk("R4 underrun data", d, 0);
    chk("R4 underrun pulse", xrun_tx, 1);

    // R7 gating
    wm_sel = 2'd0;
    dma_en = 0;
    #1;
    chk("R7 flag high", wm_tx, 1);
    chk("R7 dma gated", dma_tx, 0);

    // R8 zero reads consume
    push_pair(24'hA0A0A0, 24'hA1A1A1);
    push_pair(24'hB0B0B0, 24'hB1B1B1);
    zero_rd = 1;
    rd_word(1'b0, d); chk("R8 zero left", d, 0);
    rd_word(1'b1, d); chk("R8 zero right", d, 0);
    zero_rd = 0;
    rd_word(1'b0, d); chk("R8 next left", d, 24'hB0B0B0);
    rd_word(1'b1, d); chk("R8 next right", d, 24'hB1B1B1);
    chk("R8 empty after", wm_tx, 1);

    // R9 writes rejected
    wr_off = 1;
    push_pair(24'hC0C0C0, 24'hC1C1C1);
    wr_off = 0;
    chk("R9 still empty", wm_tx, 1);
    rd_word(1'b0, d);
    chk("R9 read underruns", xrun_tx, 1);
    chk("R9 read data", d, 0);

    // R10 collapse to oldest pair
    push_pair(24'hD0D0D0, 24'hD1D1D1);
    push_pair(24'hE0E0E0, 24'hE1E1E1);
    push_pair(24'hF0F0F0, 24'hF1F1F1);
    reset_one = 1; wr_l = 1; wr_data = 24'h777777;
    @(negedge clk);
    reset_one = 0; wr_l = 0;
    chk("R10 rx flag one stored", wm_rx, 1);
    chk("R10 tx flag one stored", wm_tx, 0);
    rd_word(1'b0, d); chk("R10 left", d, 24'hD0D0D0);
    rd_word(1'b1, d); chk("R10 right", d, 24'hD1D1D1);
    rd_word(1'b0, d); chk("R10 then empty", xrun_tx, 1);

    // R11 write-side auto-sync
    autosync = 1;
    wr_word(1'b0, 24'h111111);
    chk("R11 no resync first left", resync_tx, 0);
    wr_word(1'b0, 24'h222222);
    chk("R11 resync on double left", resync_tx, 1);
    wr_word(1'b1, 24'h333333);
    chk("R11 no resync on pair", resync_tx, 0);
    wr_word(1'b1, 24'h444444);
    chk("R11 resync on orphan right", resync_tx, 1);
    rd_word(1'b0, d); chk("R11 left kept", d, 24'h222222);
    rd_word(1'b1, d); chk("R11 right kept", d, 24'h333333);
    rd_word(1'b0, d); chk("R11 orphan dropped", xrun_tx, 1);

    // R12 read-side auto-sync
    push_pair(24'h515151, 24'h525252);
    push_pair(24'h616161, 24'h626262);
    rd_word(1'b0, d); chk("R12 first left", d, 24'h515151);
    rd_word(1'b0, d); chk("R12 skip to next left", d, 24'h616161);
    chk("R12 resync on double left", resync_tx, 1);
    rd_word(1'b1, d); chk("R12 right of new pair", d, 24'h626262);
    rd_word(1'b0, d); chk("R12 empty after", xrun_tx, 1);
    push_pair(24'h717171, 24'h727272);
    rd_word(1'b1, d); chk("R12 right first", d, 24'h727272);
    chk("R12 resync on right first", resync_tx, 1);
    rd_word(1'b0, d); chk("R12 pair freed", xrun_tx, 1);

    // R13 strict alternation
    autosync = 0;
    wr_word(1'b1, 24'h818181);
    chk("R13 no resync", resync_tx, 0);
    wr_word(1'b0, 24'h828282);
    chk("R13 no resync 2", resync_tx, 0);
    rd_word(1'b1, d); chk("R13 right strobe gets left slot", d, 24'h818181);
    rd_word(1'b0, d); chk("R13 left strobe gets right slot", d, 24'h828282);
    chk("R13 no read resync", resync_tx, 0);
    chk("R13 empty after", wm_tx, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule